// File: doc/BRIEF.md
# I2C Channel Selector

This block is an I2C target that fans one upstream bus out to 2, 4 or 8 downstream channels. A single 8-bit control register is reached with plain one-byte transactions, with no sub-address: an address byte with the write bit set followed by one data byte, or an address byte with the read bit set followed by one returned byte. The register contents decide which per-channel enable outputs are high. Those outputs are meant to steer pass gates outside this block.

Two build parameters pick the variant. In mux mode at most one channel is connected, chosen by an index and an enable bit. In switch mode every bit of the register connects its own channel. Each channel has an active-low interrupt input. These inputs are combined into one active-low interrupt output. On 2- and 4-channel builds they are also reported in the upper nibble of the byte returned by a read. SCL and SDA arrive as sampled levels and are synchronised inside the block. SDA is driven open-drain through an output enable.

Top module: `i2c_chan_sel`

## Requirements
- R1: After reset every channel enable is 0, the interrupt output is high while no input is low, and a read returns 0x00.
- R2: The block acknowledges only an address byte whose upper seven bits equal parameter ADDR. Any other address gets no acknowledge, and the data that follows has no effect on the enables.
- R3: In mux mode the index sits in the low bits (bits 1:0 for 4 channels) and the enable bit is bit 2 for 2 or 4 channels and bit 3 for 8 channels. With the enable bit set, only the channel named by the index is enabled. With it clear, no channel is enabled.
- R4: In mux mode, written bits above the index width and the enable bit are dropped: they neither alter the enables nor read back. The enables are always one-hot or all zero.
- R5: In switch mode, register bit n enables channel n, any combination at once, and the written byte reads back unchanged on an 8-channel build.
- R6: Writing 0x00 disconnects every channel in either mode.
- R7: On 2- and 4-channel builds a read returns the register in bits 3:0, and bit 4+n is 1 while interrupt input n is low. An 8-channel build returns the register byte.
- R8: The interrupt output is low one clock after any interrupt input is low. It is high one clock after all inputs are high, whatever the enables are.
- R9: A write takes effect on the falling SCL edge that ends the eighth data bit, which opens the acknowledge slot. The enables change on the next clock. A transaction stopped before the eighth data bit leaves the register unchanged.
- R10: The block starts driving SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the I2C lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| irq_n_i | input | NCH | Active-low interrupt from each channel |
| irq_n_o | output | 1 | Combined active-low interrupt |
| ch_en_o | output | NCH | Per-channel connect enable |

## Verification
An interrupt input can change during the same read transaction that snapshots the pending flags. The bench asserts a channel interrupt before the read's address byte and then reads a byte. It checks that the combined output is already low and that the returned byte carries the flag next to the control bits. A mux build and a switch build share one bus at different addresses. Because of this, each write to one device is also a wrong-address write to the other, and the other device's enables must stay where they were.

// File: rtl/i2c_chan_sel.sv
module i2c_chan_sel #(
  parameter int       NCH  = 4,
  parameter bit       MUX  = 1'b1,
  parameter bit [6:0] ADDR = 7'h70
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_oe,
  input  logic [NCH-1:0] irq_n_i,
  output logic           irq_n_o,
  output logic [NCH-1:0] ch_en_o
);
  localparam int       IW   = $clog2(NCH);
  localparam int       EN   = (NCH == 8) ? 3 : 2;
  localparam bit [7:0] KEEP = MUX ? ((8'(1) << EN) | 8'(NCH - 1)) : 8'((1 << NCH) - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACKA, S_WDAT, S_ACKD, S_RDAT, S_RACK} st_t;

  st_t        st;
  logic [2:0] scl_sh, sda_sh;
  logic [3:0] cnt;
  logic [7:0] sr, tx, ctrl, rd_byte;
  logic       rw, mack;
  logic [NCH-1:0] irq_q;

  wire scl_q = scl_sh[1], scl_p = scl_sh[2];
  wire sda_q = sda_sh[1], sda_p = sda_sh[2];
  wire rise  = scl_q & ~scl_p;
  wire fall  = ~scl_q & scl_p;
  wire start_det = scl_q & scl_p & sda_p & ~sda_q;
  wire stop_det  = scl_q & scl_p & ~sda_p & sda_q;
  wire wr_commit = ~start_det & ~stop_det & fall & (st == S_WDAT) & (cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      irq_q  <= '1;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
      irq_q  <= irq_n_i;
    end

  assign irq_n_o = &irq_q;

  generate
    if (NCH <= 4) begin : g_rd_irq
      logic [3:0] pend;
      assign pend    = 4'(~irq_q);
      assign rd_byte = {pend, 4'b0} | ctrl;
    end else begin : g_rd_plain
      assign rd_byte = ctrl;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      sr   <= '0;
      tx   <= '0;
      ctrl <= '0;
      rw   <= 1'b0;
      mack <= 1'b0;
    end else if (start_det) begin
      st  <= S_ADDR;
      cnt <= '0;
    end else if (stop_det) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_ADDR, S_WDAT: begin
          if (rise) begin
            sr  <= {sr[6:0], sda_q};
            cnt <= cnt + 4'd1;
          end else if (fall && cnt == 4'd8) begin
            if (st == S_WDAT) begin
              ctrl <= sr & KEEP;
              st   <= S_ACKD;
            end else if (sr[7:1] == ADDR) begin
              rw <= sr[0];
              st <= S_ACKA;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_ACKA: if (fall) begin
          cnt <= '0;
          if (rw) begin
            tx <= rd_byte;
            st <= S_RDAT;
          end else begin
            st <= S_WDAT;
          end
        end
        S_ACKD: if (fall) begin
          cnt <= '0;
          st  <= S_WDAT;
        end
        S_RDAT: begin
          if (rise) cnt <= cnt + 4'd1;
          else if (fall) begin
            if (cnt == 4'd8) st <= S_RACK;
            else tx <= {tx[6:0], 1'b0};
          end
        end
        S_RACK: begin
          if (rise) mack <= ~sda_q;
          else if (fall) begin
            if (mack) begin
              tx  <= rd_byte;
              cnt <= '0;
              st  <= S_RDAT;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end

  always_comb
    case (st)
      S_ACKA, S_ACKD: sda_oe = 1'b1;
      S_RDAT:         sda_oe = ~tx[7];
      default:        sda_oe = 1'b0;
    endcase

  generate
    if (MUX) begin : g_mux
      logic [NCH-1:0] one;
      assign one     = NCH'(1);
      assign ch_en_o = ctrl[EN] ? (one << ctrl[IW-1:0]) : '0;

      p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_en_o));
    end else begin : g_sw
      assign ch_en_o = ctrl[NCH-1:0];
    end
  endgenerate

  p_irq_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(&$past(irq_n_i)) |-> !irq_n_o);
  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(irq_n_i)) |-> irq_n_o);
  p_en_on_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_en_o) |-> $past(wr_commit));
  p_sda_low_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_q));
endmodule

// File: tb/test_i2c_chan_sel.sv
module test_i2c_chan_sel;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic oe_a, oe_b, irqo_a, irqo_b;
  logic [3:0] irq_a = '1, en_a;
  logic [7:0] irq_b = '1, en_b;
  wire sda = sda_m & ~oe_a & ~oe_b;
  int errors = 0, checks = 0, viol = 0;
  bit done = 1'b0;
  localparam int H = 20;

  always #2.5 clk = ~clk;

  i2c_chan_sel #(.NCH(4), .MUX(1'b1), .ADDR(7'h70)) i_i2c_chan_sel (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(oe_a),
    .irq_n_i(irq_a), .irq_n_o(irqo_a), .ch_en_o(en_a));
  i2c_chan_sel #(.NCH(8), .MUX(1'b0), .ADDR(7'h74)) i_i2c_chan_sel_sw (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(oe_b),
    .irq_n_i(irq_b), .irq_n_o(irqo_b), .ch_en_o(en_b));

  // R10 monitor: a device-driven change of SDA must not start while SCL is high
  logic oe_p = 1'b0, scl_p = 1'b1;
  always @(posedge clk) begin
    if (rst_n && scl && scl_p && (oe_a | oe_b) && !oe_p) viol++;
    oe_p  <= oe_a | oe_b;
    scl_p <= scl;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; scl = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl = 1'b0; wt(H);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wt(H);
    scl = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic wbit(input bit b);
    sda_m = b; wt(H);
    scl = 1'b1; wt(H);
    scl = 1'b0; wt(H);
  endtask

  task automatic rbit(output bit b);
    sda_m = 1'b1; wt(H);
    scl = 1'b1; wt(H / 2);
    b = sda; wt(H / 2);
    scl = 1'b0; wt(H);
  endtask

  task automatic wbyte(input logic [7:0] d, output bit nack);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(nack);
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] d, output bit nack);
    bit n1, n2;
    n2 = 1'b0;
    i2c_start;
    wbyte({a, 1'b0}, n1);
    if (!n1) wbyte(d, n2);
    i2c_stop;
    nack = n1 | n2;
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [7:0] d);
    bit n, b;
    i2c_start;
    wbyte({a, 1'b1}, n);
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(1'b1);
    i2c_stop;
  endtask

  // {write byte, expected 4-ch mux enables, expected readback control nibble}
  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{
    {8'h04, 4'b0001, 4'h4}, {8'h05, 4'b0010, 4'h5}, {8'h06, 4'b0100, 4'h6},
    {8'h07, 4'b1000, 4'h7}, {8'h03, 4'b0000, 4'h3}, {8'h0D, 4'b0010, 4'h5},
    {8'hFE, 4'b0100, 4'h6}, {8'hF8, 4'b0000, 4'h0}, {8'h00, 4'b0000, 4'h0}
  };

  initial begin
    wt(500000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    bit nk;
    logic [3:0] en_prev;
    wt(10);
    rst_n = 1'b1;
    wt(10);
    chk("R1 enables A", en_a, 0);
    chk("R1 enables B", en_b, 0);
    chk("R1 irq out", irqo_a, 1);
    rd_reg(7'h70, rd);
    chk("R1 readback", rd, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr_reg(7'h70, VEC[i][15:8], nk);
      chk("R3 ack", nk, 0);
      chk((i >= 5) ? "R4 enables" : "R3 enables", en_a, VEC[i][7:4]);
      rd_reg(7'h70, rd);
      chk((i >= 5) ? "R4 readback" : "R7 readback", rd, {4'h0, VEC[i][3:0]});
      chk("R2 other device untouched", en_b, 0);
    end
    chk("R6 mux zero", en_a, 0);

    wr_reg(7'h74, 8'hA5, nk);
    chk("R5 ack", nk, 0);
    chk("R5 enables", en_b, 8'hA5);
    rd_reg(7'h74, rd);
    chk("R5 readback", rd, 8'hA5);
    wr_reg(7'h74, 8'hFF, nk);
    chk("R5 all", en_b, 8'hFF);
    wr_reg(7'h74, 8'h00, nk);
    chk("R6 switch zero", en_b, 0);

    wr_reg(7'h70, 8'h06, nk);
    wr_reg(7'h71, 8'h04, nk);
    chk("R2 nack", nk, 1);
    chk("R2 unchanged", en_a, 4'b0100);

    irq_a = 4'b1011;
    wt(3);
    chk("R8 irq low", irqo_a, 0);
    chk("R8 enables untouched", en_a, 4'b0100);
    wr_reg(7'h70, 8'h05, nk);
    rd_reg(7'h70, rd);
    chk("R7 pending flag", rd, 8'h45);
    irq_a = 4'b1111;
    wt(3);
    chk("R8 irq released", irqo_a, 1);
    irq_b = 8'h7F;
    wt(3);
    chk("R8 irq B low", irqo_b, 0);
    chk("R8 irq A independent", irqo_a, 1);
    rd_reg(7'h74, rd);
    chk("R7 8ch no flags", rd, 8'h00);
    irq_b = 8'hFF;
    wt(3);
    chk("R8 irq B released", irqo_b, 1);

    en_prev = en_a;
    i2c_start;
    wbyte({7'h70, 1'b0}, nk);
    for (int i = 0; i < 5; i++) wbit(1'b1);
    i2c_stop;
    chk("R9 aborted write", en_a, en_prev);

    i2c_start;
    wbyte({7'h70, 1'b0}, nk);
    for (int i = 7; i >= 1; i--) wbit(i == 2);
    chk("R9 before last bit", en_a, en_prev);
    wbit(1'b0);
    chk("R9 at ack slot", en_a, 4'b0001);
    rbit(nk);
    chk("R9 ack", nk, 0);
    i2c_stop;

    chk("R10 sda changes", viol, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule